// File: doc/BRIEF.md
# DDS Frequency-Load Serial Sequencer

This block loads one of the two frequency registers of a direct digital synthesizer over a three-wire serial link. The system side presents a 28-bit tuning word, a register-select bit and a clock-divider setting, then pulses a start strobe. The sequencer captures those inputs and sends three 16-bit frames, each framed by an active-low sync line. The first frame is a control word that tells the synthesizer a two-part frequency write follows. The second frame carries the lower 14 bits of the tuning word and the third carries the upper 14 bits. Each frequency frame carries the address prefix of the chosen register.

The serial clock is derived from the system clock. Its high and low phases each last a programmable number of system cycles. Between frames the sync line stays high for a fixed, parameterised gap. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end. Computing the tuning word from a frequency in hertz happens elsewhere.

Top module: `ddsLoadSeq`

## Requirements
- R1: After reset and whenever the sequencer is idle, the sync line is high, the serial clock is high, the data line is low, and busy and done are low.
- R2: Each frame holds the sync line low for exactly 16 data bits, sent most significant bit (bit 15) first. Each bit is valid on the data line while the serial clock is high and stays stable through the following clock-low phase.
- R3: The frames go out in a fixed order. The first frame is the control word 0x2000: bits 15:14 = 00 (control) and bit 13 = 1 (two-part frequency write), with every other bit zero.
- R4: The second frame carries tuning-word bits 13:0 in frame bits 13:0, and the third frame carries tuning-word bits 27:14 in frame bits 13:0. In both frames, bits 15:14 = 01 when the register select is 0 and 10 when it is 1. For example, word 0x369D03 to register 0 gives frames 0x2000, 0x5D03, 0x40DA.
- R5: Every serial-clock high phase and every low phase inside a frame lasts phaseDiv+1 system cycles. The clock is high when the sync line falls and when it rises.
- R6: Between consecutive frames of one sequence, the sync line stays high for exactly GAP_CYC system cycles.
- R7: A start is accepted only when the sequencer is not busy. After acceptance, busy is high and the sync line is low in the next cycle. A start while busy has no effect, and changes to the inputs after acceptance do not alter the frames sent.
- R8: A start accepted at a clock edge raises done exactly 3*(32*(phaseDiv+1)+GAP_CYC) edges later. The sync line has then been high for GAP_CYC cycles after the third frame. Done lasts one cycle, busy is low while done is high, and no further frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to send a load sequence |
| tuneWord | input | 28 | Frequency tuning word |
| regSel | input | 1 | Target frequency register (0 or 1) |
| phaseDiv | input | DIV_W | Serial-clock phase length minus one, in system cycles |
| sclkOut | output | 1 | Serial clock to the synthesizer |
| syncN | output | 1 | Active-low frame sync |
| sdataOut | output | 1 | Serial data, MSB first |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with DIV_W = 4 and GAP_CYC = 3. It runs divider settings 0, 2 and 3, so the shortest one-cycle clock phases are measured next to stretched ones. A gap of three cycles is easy to tell apart from a one-cycle minimum or an off-by-one count. The narrow divider keeps every sequence to a few hundred cycles. This leaves room for all-ones, all-zeros and mixed tuning words to both registers. It also leaves room for a mid-sequence start, with inputs that change, to show that the captured values win.

// File: rtl/ddsSeqPkg.sv
package ddsSeqPkg;

  localparam int FRAME_W    = 16;
  localparam int HALF_W     = 14;
  localparam int TUNE_W     = 2 * HALF_W;
  localparam int BIT_W      = $clog2(FRAME_W);
  localparam int FRAMES     = 3;

  localparam logic [FRAME_W-1:0] CTRL_WORD  = 16'h2000;
  localparam logic [1:0]         PFX_REG0   = 2'b01;
  localparam logic [1:0]         PFX_REG1   = 2'b10;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_LOW  = 2'd1;
  localparam logic [1:0] SEL_HIGH = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_GAP  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic       latchIn;
    logic       loadFrame;
    logic       shiftBit;
    logic       phaseLoad;
    logic [1:0] frameSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/ddsSeqPath.sv
module ddsSeqPath
  import ddsSeqPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [TUNE_W-1:0] tuneWord,
  input  logic              regSel,
  input  logic [DIV_W-1:0]  phaseDiv,
  output logic              sdataOut,
  output logic              phaseDone
);

  logic [TUNE_W-1:0]  wordQ;
  logic               selQ;
  logic [DIV_W-1:0]   divQ;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] frameMux;
  logic [DIV_W-1:0]   phaseCnt;
  logic [DIV_W-1:0]   phaseSrc;
  logic [1:0]         prefix;

  // capture of the request inputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
      selQ  <= 1'b0;
      divQ  <= '0;
    end else if (strb.latchIn) begin
      wordQ <= tuneWord;
      selQ  <= regSel;
      divQ  <= phaseDiv;
    end
  end

  assign prefix = selQ ? PFX_REG1 : PFX_REG0;

  // frame builder; the control frame needs no captured data
  always_comb begin
    unique case (strb.frameSel)
      SEL_LOW:  frameMux = {prefix, wordQ[HALF_W-1:0]};
      SEL_HIGH: frameMux = {prefix, wordQ[TUNE_W-1:HALF_W]};
      default:  frameMux = CTRL_WORD;
    endcase
  end

  // output shift register, MSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.loadFrame) begin
      shiftReg <= frameMux;
    end else if (strb.shiftBit) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdataOut = shiftReg[FRAME_W-1];

  // clock phase timer; uses the live divider on the accepting cycle
  assign phaseSrc = strb.latchIn ? phaseDiv : divQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strb.phaseLoad) begin
      phaseCnt <= phaseSrc;
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - 1'b1;
    end
  end

  assign phaseDone = (phaseCnt == '0);

endmodule

// File: rtl/ddsSeqCtrl.sv
module ddsSeqCtrl
  import ddsSeqPkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        phaseDone,
  output ctrlStrobe_t strb,
  output logic        sclkOut,
  output logic        syncN,
  output logic        busy,
  output logic        done
);

  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST   = GAP_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(FRAME_W - 1);
  localparam logic [1:0]       LAST_FRAME = 2'(FRAMES - 1);

  seqState_t        st, stNext;
  logic [BIT_W-1:0] bitCnt, bitNext;
  logic [1:0]       frameCnt, frmNext;
  logic [GAP_W-1:0] gapCnt, gapNext;
  logic             syncNext, sclkNext, busyNext, doneNext;

  always_comb begin
    stNext   = st;
    bitNext  = bitCnt;
    frmNext  = frameCnt;
    gapNext  = gapCnt;
    syncNext = syncN;
    sclkNext = sclkOut;
    busyNext = busy;
    doneNext = 1'b0;
    strb     = '0;
    unique case (st)
      ST_IDLE: begin
        if (startReq) begin
          strb.latchIn   = 1'b1;
          strb.loadFrame = 1'b1;
          strb.frameSel  = SEL_CTRL;
          strb.phaseLoad = 1'b1;
          syncNext       = 1'b0;
          sclkNext       = 1'b1;
          busyNext       = 1'b1;
          bitNext        = LAST_BIT;
          frmNext        = 2'd0;
          stNext         = ST_HI;
        end
      end
      ST_HI: begin
        if (phaseDone) begin
          sclkNext       = 1'b0;
          strb.phaseLoad = 1'b1;
          stNext         = ST_LO;
        end
      end
      ST_LO: begin
        if (phaseDone) begin
          sclkNext      = 1'b1;
          strb.shiftBit = 1'b1;
          if (bitCnt == '0) begin
            syncNext = 1'b1;
            gapNext  = GAP_LAST;
            stNext   = ST_GAP;
          end else begin
            bitNext        = bitCnt - 1'b1;
            strb.phaseLoad = 1'b1;
            stNext         = ST_HI;
          end
        end
      end
      ST_GAP: begin
        if (gapCnt == '0) begin
          if (frameCnt == LAST_FRAME) begin
            busyNext = 1'b0;
            doneNext = 1'b1;
            stNext   = ST_IDLE;
          end else begin
            frmNext        = frameCnt + 2'd1;
            strb.loadFrame = 1'b1;
            strb.frameSel  = frameCnt + 2'd1;
            strb.phaseLoad = 1'b1;
            syncNext       = 1'b0;
            bitNext        = LAST_BIT;
            stNext         = ST_HI;
          end
        end else begin
          gapNext = gapCnt - 1'b1;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      bitCnt   <= '0;
      frameCnt <= '0;
      gapCnt   <= '0;
      syncN    <= 1'b1;
      sclkOut  <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      st       <= stNext;
      bitCnt   <= bitNext;
      frameCnt <= frmNext;
      gapCnt   <= gapNext;
      syncN    <= syncNext;
      sclkOut  <= sclkNext;
      busy     <= busyNext;
      done     <= doneNext;
    end
  end

endmodule

// File: rtl/ddsLoadSeq.sv
module ddsLoadSeq
  import ddsSeqPkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [TUNE_W-1:0] tuneWord,
  input  logic              regSel,
  input  logic [DIV_W-1:0]  phaseDiv,
  output logic              sclkOut,
  output logic              syncN,
  output logic              sdataOut,
  output logic              busy,
  output logic              done
);

  ctrlStrobe_t strb;
  logic        phaseDone;

  ddsSeqCtrl #(.GAP_CYC(GAP_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .phaseDone(phaseDone),
    .strb     (strb),
    .sclkOut  (sclkOut),
    .syncN    (syncN),
    .busy     (busy),
    .done     (done)
  );

  ddsSeqPath #(.DIV_W(DIV_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .tuneWord (tuneWord),
    .regSel   (regSel),
    .phaseDiv (phaseDiv),
    .sdataOut (sdataOut),
    .phaseDone(phaseDone)
  );

endmodule

// File: rtl/ddsLoadSeqChk.sv
module ddsLoadSeqChk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic sclkOut,
  input logic syncN,
  input logic sdataOut,
  input logic busy,
  input logic done
);

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (syncN && sclkOut && !sdataOut)); // R1

  AST_DATA_STABLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!sclkOut && $past(!sclkOut)) |-> $stable(sdataOut)); // R2

  AST_SYNC_FALL_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncN) |-> sclkOut); // R5

  AST_SYNC_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncN) |-> sclkOut); // R5

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> (busy && !syncN)); // R7

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && syncN)); // R8

endmodule

bind ddsLoadSeq ddsLoadSeqChk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .startReq(startReq),
  .sclkOut (sclkOut),
  .syncN   (syncN),
  .sdataOut(sdataOut),
  .busy    (busy),
  .done    (done)
);

// File: tb/sim_ddsLoadSeq.sv
module sim_ddsLoadSeq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 4;
  localparam int GAP_CYC    = 3;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [27:0]       tuneWord = '0;
  logic              regSel = 1'b0;
  logic [DIV_W-1:0]  phaseDiv = '0;
  logic              sclkOut, syncN, sdataOut, busy, done;

  int tests = 0;
  int fails = 0;
  int expP  = 1;
  logic [15:0] expQ[$];

  ddsLoadSeq #(.DIV_W(DIV_W), .GAP_CYC(GAP_CYC)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tuneWord(tuneWord),
    .regSel(regSel), .phaseDiv(phaseDiv), .sclkOut(sclkOut), .syncN(syncN),
    .sdataOut(sdataOut), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      check(1'b0, "watchdog", cyc, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // monitor: rebuilds frames from the serial lines and checks timing
  logic prevSync = 1'b1, prevSclk = 1'b1;
  int   nBits = 0, hiRun = 0, loRun = 0, syncHi = 0, seqFrm = 0;
  logic [15:0] cap = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevSync && !syncN) begin
        if (seqFrm != 0) check(syncHi == GAP_CYC, "R6 gap", syncHi, GAP_CYC);
        check(sclkOut == 1'b1, "R5 clk high at sync fall", sclkOut, 1);
        nBits = 0; cap = '0;
      end
      if (syncN) syncHi = prevSync ? syncHi + 1 : 1;
      if (!syncN && sclkOut) hiRun = (prevSync || !prevSclk) ? 1 : hiRun + 1;
      if (!sclkOut) loRun = prevSclk ? 1 : loRun + 1;
      if (!syncN && !sclkOut && prevSclk) begin
        check(hiRun == expP, "R5 high phase", hiRun, expP);
        cap = {cap[14:0], sdataOut};
        nBits++;
      end
      if (sclkOut && !prevSclk) check(loRun == expP, "R5 low phase", loRun, expP);
      if (!prevSync && syncN) begin
        check(nBits == 16, "R2 bit count", nBits, 16);
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected frame", cap, 0);
        end else begin
          logic [15:0] e;
          e = expQ.pop_front();
          if (seqFrm == 0) check(cap == e, "R3 control frame", cap, e);
          else check(cap == e, "R4 frequency frame", cap, e);
        end
        seqFrm = (seqFrm + 1) % 3;
      end
      prevSync = syncN;
      prevSclk = sclkOut;
    end
  end

  // driver: pushes expected frames and runs one sequence
  task automatic runSeq(input logic [27:0] w, input logic sel,
                        input logic [DIV_W-1:0] div, input bit poke);
    int cnt;
    int expCyc;
    logic [1:0] pfx;
    pfx = sel ? 2'b10 : 2'b01;
    expP = int'(div) + 1;
    expCyc = 3 * (32 * expP + GAP_CYC) + 1;
    expQ.push_back(16'h2000);
    expQ.push_back({pfx, w[13:0]});
    expQ.push_back({pfx, w[27:14]});
    @(negedge clk);
    tuneWord = w; regSel = sel; phaseDiv = div; startReq = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      startReq = 1'b0;
      if (poke && cnt == 40) begin
        startReq = 1'b1; tuneWord = ~w; regSel = ~sel; phaseDiv = div ^ 4'd1;
      end
    end while (!done && cnt < 20000);
    check(cnt == expCyc, "R8 done timing", cnt, expCyc);
    check(busy == 1'b0, "R8 busy low with done", busy, 0);
    check(expQ.size() == 0, "R3 all frames before done", expQ.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
    if (poke) begin
      repeat (30) @(negedge clk);
      check(syncN && !busy, "R7 no restart from ignored start", {syncN, busy}, 2);
      check(expQ.size() == 0, "R7 queue drained", expQ.size(), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(syncN == 1'b1, "R1 sync after reset", syncN, 1);
    check(sclkOut == 1'b1, "R1 clk after reset", sclkOut, 1);
    check(sdataOut == 1'b0, "R1 data after reset", sdataOut, 0);
    check(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(syncN && sclkOut && !sdataOut && !busy, "R1 idle lines",
          {syncN, sclkOut, sdataOut, busy}, 4'b1100);

    runSeq(28'h0369D03, 1'b0, 4'd0, 1'b0);   // frames 2000 5D03 40DA
    runSeq(28'h0369D03, 1'b1, 4'd3, 1'b0);
    runSeq(28'hFFFFFFF, 1'b1, 4'd0, 1'b0);
    runSeq(28'h0000000, 1'b0, 4'd2, 1'b0);
    runSeq(28'hA5C3F0E, 1'b0, 4'd3, 1'b1);   // R7 ignored start, changed inputs
    runSeq(28'h1234567, 1'b1, 4'd0, 1'b1);

    check(syncN && sclkOut && !sdataOut && !busy, "R1 idle at end",
          {syncN, sclkOut, sdataOut, busy}, 4'b1100);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule